// File: doc/BRIEF.md
# SPI Collision and Mode Fault Monitor

This unit sits next to an SPI shift engine and guards it against two system errors. It watches CPU bus accesses to four small registers (data, status, control, pin direction), the slave-select pin, and the edge strobes that the shifter reports. It passes a CPU write to the data register on to the shifter only when the current mode and clock phase allow it. A write at any other time is dropped, so the byte being shifted is not corrupted, and a write-collision flag is set.

The unit also detects a second master on the bus. It does this when it is an enabled master and sees the slave-select line pulled low. In that case it sets a mode-fault flag, drops the enable and master bits, and clears the pin output enables so that the pins float. Each flag is cleared by software through its own two-step access sequence, and any unrelated access between the two steps cancels that sequence.

Register map on `bus_sel`:

| Code | Register | Bit assignment |
|------|----------|----------------|
| 0 | data | reads return `rx_byte`; writes go to the shifter |
| 1 | status | bit0 collision, bit1 mode fault |
| 2 | control | bit0 enable, bit1 master, bit2 clock phase, bit3 bidirectional |
| 3 | direction | bit0 SCK drive, bit1 MOSI drive, bit2 MISO drive, bit3 slave-select used as output/general pin |

Top module: `spi_fault_monitor`

## Requirements
- R1: After reset both flags, the control register and the direction register read 0. The slave-select pin passes through a two-flop synchronizer, so a low level on the pin can set the mode fault no earlier than on the third clock edge after it appears.
- R2: With enable=1 and master=1, a data write is forwarded (`data_wr_stb`=1 in the same cycle) only while the synchronized slave-select is high. Otherwise it collides.
- R3: With enable=1, master=0 and clock phase 0, a data write is forwarded only while the synchronized slave-select is high.
- R4: With enable=1, master=0 and clock phase 1, a data write is also legal while slave-select is low, provided it comes after a `last_edge` strobe. Writes in the strobe cycle and in the two cycles after it collide. From the third cycle after the strobe, writes are legal until the next `sck_edge` strobe or a falling edge of the synchronized slave-select.
- R5: A colliding data write is not forwarded, and it sets the collision flag on the next clock edge. While enable=0, every data write is forwarded.
- R6: `irq_req` is high exactly while the mode-fault flag is set. A collision alone never raises it.
- R7: A status read taken while the collision flag is set arms its clear. If the next bus access is a data read or data write, that access clears the flag. Any other access first cancels the armed clear. A colliding data write keeps the flag set.
- R8: The mode-fault flag sets one edge after the synchronized slave-select is seen low while enable=1, master=1 and direction bit3=0. A slave never faults.
- R9: While direction bit3=1, mode-fault detection is off and the flag stays 0.
- R10: A mode fault clears enable, master and the SCK, MOSI and MISO drive bits.
- R11: With bidirectional=1, a mode fault leaves the MISO drive bit unchanged.
- R12: A status read taken while the mode-fault flag is set arms its clear. If the next bus access is a control write, that write clears the flag. Any other access first cancels the armed clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n_pin | input | 1 | Slave-select pin level, asynchronous |
| sck_edge | input | 1 | Strobe from the shifter: an SCK edge of a transfer |
| last_edge | input | 1 | Strobe from the shifter: the final SCK edge of a byte |
| bus_sel | input | 2 | Register select |
| bus_rd | input | 1 | Bus read this cycle |
| bus_wr | input | 1 | Bus write this cycle |
| bus_wdata | input | DW | Write data |
| rx_byte | input | DW | Received byte, returned on data reads |
| bus_rdata | output | DW | Read data for the selected register |
| data_wr_stb | output | 1 | Accepted data write, forwarded to the shifter |
| data_wr_val | output | DW | Data for the forwarded write |
| spi_en | output | 1 | Enable bit |
| master_sel | output | 1 | Master bit |
| cpha_sel | output | 1 | Clock phase bit |
| bidir_sel | output | 1 | Bidirectional mode bit |
| oe_sck | output | 1 | SCK drive enable |
| oe_mosi | output | 1 | MOSI drive enable |
| oe_miso | output | 1 | MISO drive enable |
| ss_out | output | 1 | Slave-select configured as output/general pin |
| wcol_flag | output | 1 | Write-collision flag |
| modf_flag | output | 1 | Mode-fault flag |
| irq_req | output | 1 | Interrupt request (mode fault only) |

## Verification
A collision and the completion of the collision-clear sequence can happen in the same cycle. This occurs when the data write that follows an arming status read is itself outside the legal window. The bench sets this up with a master that has slave-select low and the fault check turned off. It reads status while the flag is set, then issues an illegal data write. It checks that the write is not forwarded and that the flag is still set afterwards. A further arming read followed by a data read must then clear the flag.

// File: rtl/spi_fault_monitor.sv
module spi_fault_monitor #(
  parameter int DW          = 8,
  parameter int BLACKOUT    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ss_n_pin,
  input  logic          sck_edge,
  input  logic          last_edge,
  input  logic [1:0]    bus_sel,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] bus_rdata,
  output logic          data_wr_stb,
  output logic [DW-1:0] data_wr_val,
  output logic          spi_en,
  output logic          master_sel,
  output logic          cpha_sel,
  output logic          bidir_sel,
  output logic          oe_sck,
  output logic          oe_mosi,
  output logic          oe_miso,
  output logic          ss_out,
  output logic          wcol_flag,
  output logic          modf_flag,
  output logic          irq_req
);
  localparam int BW = $clog2(BLACKOUT + 1);
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;
  localparam logic [1:0] SEL_DIR  = 2'd3;

  logic [SYNC_STAGES-1:0] ss_sync;
  logic ss_s, ss_d, ss_fall;
  logic en_q, mst_q, cpha_q, bidir_q;
  logic sck_oe_q, mosi_oe_q, miso_oe_q, ss_out_q;
  logic wcol_q, modf_q, arm_w, arm_m;
  logic win_q;
  logic [BW-1:0] blk_q;

  // slave-select synchronizer, idles high
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ss_sync <= '1;
      ss_d    <= 1'b1;
    end else begin
      ss_sync <= {ss_sync[SYNC_STAGES-2:0], ss_n_pin};
      ss_d    <= ss_s;
    end

  assign ss_s    = ss_sync[SYNC_STAGES-1];
  assign ss_fall = ss_d && !ss_s;

  wire acc      = bus_rd || bus_wr;
  wire data_acc = acc && (bus_sel == SEL_DATA);
  wire data_wr  = bus_wr && (bus_sel == SEL_DATA);
  wire stat_rd  = bus_rd && (bus_sel == SEL_STAT);
  wire ctl_wr   = bus_wr && (bus_sel == SEL_CTL);
  wire dir_wr   = bus_wr && (bus_sel == SEL_DIR);

  wire blk_done = (blk_q == '0);
  wire slave_tt = !mst_q && cpha_q && win_q && blk_done;
  wire legal    = !en_q || ss_s || slave_tt;
  wire collide  = data_wr && !legal;
  wire fault    = en_q && mst_q && !ss_out_q && !ss_s;

  // phase-1 slave window after the last SCK edge
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      win_q <= 1'b0;
      blk_q <= '0;
    end else begin
      if (last_edge)                win_q <= 1'b1;
      else if (sck_edge || ss_fall) win_q <= 1'b0;
      if (last_edge)      blk_q <= BW'(BLACKOUT);
      else if (!blk_done) blk_q <= blk_q - 1'b1;
    end

  // collision flag and its clear sequence
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wcol_q <= 1'b0;
      arm_w  <= 1'b0;
    end else begin
      if (collide)                wcol_q <= 1'b1;
      else if (arm_w && data_acc) wcol_q <= 1'b0;
      if (stat_rd)  arm_w <= wcol_q;
      else if (acc) arm_w <= 1'b0;
    end

  // mode-fault flag and its clear sequence
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      modf_q <= 1'b0;
      arm_m  <= 1'b0;
    end else begin
      if (fault)               modf_q <= 1'b1;
      else if (arm_m && ctl_wr) modf_q <= 1'b0;
      if (stat_rd)  arm_m <= modf_q;
      else if (acc) arm_m <= 1'b0;
    end

  // control register; a fault overrides enable and master
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q    <= 1'b0;
      mst_q   <= 1'b0;
      cpha_q  <= 1'b0;
      bidir_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q    <= bus_wdata[0] && !fault;
      mst_q   <= bus_wdata[1] && !fault;
      cpha_q  <= bus_wdata[2];
      bidir_q <= bus_wdata[3];
    end else if (fault) begin
      en_q  <= 1'b0;
      mst_q <= 1'b0;
    end

  // direction register; a fault floats the pins
  wire kill_miso = fault && !bidir_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_oe_q  <= 1'b0;
      mosi_oe_q <= 1'b0;
      miso_oe_q <= 1'b0;
      ss_out_q  <= 1'b0;
    end else if (dir_wr) begin
      sck_oe_q  <= bus_wdata[0] && !fault;
      mosi_oe_q <= bus_wdata[1] && !fault;
      miso_oe_q <= bus_wdata[2] && !kill_miso;
      ss_out_q  <= bus_wdata[3];
    end else if (fault) begin
      sck_oe_q  <= 1'b0;
      mosi_oe_q <= 1'b0;
      if (kill_miso) miso_oe_q <= 1'b0;
    end

  always_comb begin
    bus_rdata = '0;
    case (bus_sel)
      SEL_DATA: bus_rdata = rx_byte;
      SEL_STAT: bus_rdata[1:0] = {modf_q, wcol_q};
      SEL_CTL:  bus_rdata[3:0] = {bidir_q, cpha_q, mst_q, en_q};
      default:  bus_rdata[3:0] = {ss_out_q, miso_oe_q, mosi_oe_q, sck_oe_q};
    endcase
  end

  assign data_wr_stb = data_wr && legal;
  assign data_wr_val = bus_wdata;
  assign spi_en      = en_q;
  assign master_sel  = mst_q;
  assign cpha_sel    = cpha_q;
  assign bidir_sel   = bidir_q;
  assign oe_sck      = sck_oe_q;
  assign oe_mosi     = mosi_oe_q;
  assign oe_miso     = miso_oe_q;
  assign ss_out      = ss_out_q;
  assign wcol_flag   = wcol_q;
  assign modf_flag   = modf_q;
  assign irq_req     = modf_q;

  assert_drop_sets_wcol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == SEL_DATA && !data_wr_stb) |=> wcol_flag);

  assert_wcol_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wcol_flag) && !modf_flag) |-> !irq_req);

  assert_wcol_clear_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wcol_flag) |-> ($past(arm_w) && $past(bus_rd || bus_wr) && $past(bus_sel) == SEL_DATA));

  assert_modf_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_out && $past(ss_out)) |-> !$rose(modf_flag));

  assert_modf_floats_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf_flag) |-> (!spi_en && !master_sel && !oe_sck && !oe_mosi));

  assert_bidir_miso_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(modf_flag) && $past(bidir_sel) && !$past(bus_wr && bus_sel == SEL_DIR))
      |-> oe_miso == $past(oe_miso));

  assert_modf_clear_path_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(modf_flag) |-> ($past(bus_wr) && $past(bus_sel) == SEL_CTL));
endmodule

// File: tb/spi_fault_monitor_tb_top.sv
module spi_fault_monitor_tb_top;
  logic clk = 0, rst_n = 0;
  logic ss_n_pin = 1, sck_edge = 0, last_edge = 0;
  logic [1:0] bus_sel = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 0, rx_byte = 8'h3C, bus_rdata, data_wr_val;
  logic data_wr_stb, spi_en, master_sel, cpha_sel, bidir_sel;
  logic oe_sck, oe_mosi, oe_miso, ss_out, wcol_flag, modf_flag, irq_req;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { string tag; int code; logic [7:0] exp; } item_t;
  item_t q[$];
  item_t it;

  always #10 clk = ~clk;

  spi_fault_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .ss_n_pin(ss_n_pin), .sck_edge(sck_edge),
    .last_edge(last_edge), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rx_byte(rx_byte), .bus_rdata(bus_rdata),
    .data_wr_stb(data_wr_stb), .data_wr_val(data_wr_val), .spi_en(spi_en),
    .master_sel(master_sel), .cpha_sel(cpha_sel), .bidir_sel(bidir_sel),
    .oe_sck(oe_sck), .oe_mosi(oe_mosi), .oe_miso(oe_miso), .ss_out(ss_out),
    .wcol_flag(wcol_flag), .modf_flag(modf_flag), .irq_req(irq_req));

  function automatic logic [7:0] obs(input int code);
    case (code)
      0: return {7'b0, wcol_flag};
      1: return {7'b0, modf_flag};
      2: return {7'b0, data_wr_stb};
      3: return {4'b0, bidir_sel, cpha_sel, master_sel, spi_en};
      4: return {4'b0, ss_out, oe_miso, oe_mosi, oe_sck};
      5: return {7'b0, irq_req};
      default: return bus_rdata;
    endcase
  endfunction

  // monitor: pops expected items and compares away from the clock edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      it = q.pop_front();
      total++;
      if (obs(it.code) !== it.exp) begin
        bad++;
        $display("FAIL %s code=%0d actual=%h expected=%h", it.tag, it.code, obs(it.code), it.exp);
      end
    end
  end

  task automatic expect_now(input string tag, input int code, input logic [7:0] e);
    item_t x;
    x.tag = tag; x.code = code; x.exp = e;
    q.push_back(x);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic bus_op(input logic rd, input logic wr, input logic [1:0] s, input logic [7:0] d);
    bus_rd = rd; bus_wr = wr; bus_sel = s; bus_wdata = d;
    step();
    bus_rd = 0; bus_wr = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] s, input logic [7:0] e);
    bus_rd = 1; bus_sel = s;
    expect_now(tag, 6, e);
    step();
    bus_rd = 0;
  endtask

  task automatic data_wr_chk(input string tag, input logic e);
    bus_wr = 1; bus_sel = 2'd0; bus_wdata = 8'hA5;
    expect_now(tag, 2, {7'b0, e});
    step();
    bus_wr = 0;
  endtask

  task automatic set_ss(input logic v);
    ss_n_pin = v;
    repeat (3) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    expect_now("R1 wcol reset", 0, 0);
    expect_now("R1 modf reset", 1, 0);
    expect_now("R1 ctrl reset", 3, 0);
    expect_now("R1 dir reset", 4, 0);
    step();

    // master with fault check off, SS low: collisions
    bus_op(0, 1, 2'd3, 8'h0F);
    bus_op(0, 1, 2'd2, 8'h03);
    data_wr_chk("R2 master ss high accepted", 1);
    expect_now("R2 no collision", 0, 0);
    set_ss(0);
    expect_now("R9 inhibited modf", 1, 0);
    data_wr_chk("R2 master ss low dropped", 0);
    expect_now("R5 wcol set", 0, 1);
    expect_now("R6 no irq on wcol", 5, 0);
    rd_chk("R7 status shows wcol", 2'd1, 8'h01);
    bus_op(1, 0, 2'd0, 0);
    expect_now("R7 wcol cleared by data read", 0, 0);

    data_wr_chk("R2 collide again", 0);
    rd_chk("R7 status arm", 2'd1, 8'h01);
    bus_op(1, 0, 2'd3, 0);
    bus_op(1, 0, 2'd0, 0);
    expect_now("R7 cancel by other access", 0, 1);
    rd_chk("R7 status arm 2", 2'd1, 8'h01);
    data_wr_chk("R7 clearing write collides", 0);
    expect_now("R7 colliding clear keeps flag", 0, 1);
    rd_chk("R7 status arm 3", 2'd1, 8'h01);
    bus_op(1, 0, 2'd0, 0);
    expect_now("R7 final clear", 0, 0);

    // mode fault with sync latency
    set_ss(1);
    bus_op(0, 1, 2'd3, 8'h07);
    bus_op(0, 1, 2'd2, 8'h03);
    ss_n_pin = 0;
    step(); expect_now("R1 sync edge1", 1, 0);
    step(); expect_now("R1 sync edge2", 1, 0);
    step();
    expect_now("R8 modf set", 1, 1);
    expect_now("R10 ctrl dropped", 3, 0);
    expect_now("R10 pins floated", 4, 0);
    expect_now("R6 irq on modf", 5, 1);
    rd_chk("R12 status shows modf", 2'd1, 8'h02);
    bus_op(0, 1, 2'd2, 8'h00);
    expect_now("R12 modf cleared", 1, 0);

    set_ss(1);
    bus_op(0, 1, 2'd2, 8'h03);
    set_ss(0);
    expect_now("R8 modf again", 1, 1);
    rd_chk("R12 arm", 2'd1, 8'h02);
    bus_op(1, 0, 2'd0, 0);
    bus_op(0, 1, 2'd2, 8'h00);
    expect_now("R12 cancel by data read", 1, 1);
    rd_chk("R12 arm 2", 2'd1, 8'h02);
    bus_op(0, 1, 2'd2, 8'h00);
    expect_now("R12 clear after rearm", 1, 0);

    // bidirectional fault keeps MISO drive
    set_ss(1);
    bus_op(0, 1, 2'd3, 8'h07);
    bus_op(0, 1, 2'd2, 8'h0B);
    set_ss(0);
    expect_now("R11 miso kept", 4, 8'h04);
    expect_now("R11 bidir ctrl", 3, 8'h08);
    rd_chk("R12 arm bidir", 2'd1, 8'h02);
    bus_op(0, 1, 2'd2, 8'h00);

    // slave phase 0
    bus_op(0, 1, 2'd3, 8'h07);
    bus_op(0, 1, 2'd2, 8'h01);
    data_wr_chk("R3 slave ph0 ss low dropped", 0);
    expect_now("R8 slave no fault", 1, 0);
    set_ss(1);
    data_wr_chk("R3 slave ph0 ss high accepted", 1);
    rd_chk("R7 arm slave", 2'd1, 8'h01);
    bus_op(1, 0, 2'd0, 0);

    // slave phase 1 window
    bus_op(0, 1, 2'd2, 8'h05);
    set_ss(0);
    data_wr_chk("R4 before last edge dropped", 0);
    last_edge = 1;
    data_wr_chk("R4 strobe cycle dropped", 0);
    last_edge = 0;
    data_wr_chk("R4 blackout 1 dropped", 0);
    data_wr_chk("R4 blackout 2 dropped", 0);
    data_wr_chk("R4 window accepted", 1);
    data_wr_chk("R4 window still open", 1);
    sck_edge = 1; step(); sck_edge = 0;
    data_wr_chk("R4 closed by sck edge", 0);
    last_edge = 1; step(); last_edge = 0;
    repeat (3) step();
    set_ss(1);
    set_ss(0);
    data_wr_chk("R4 closed by ss fall", 0);

    // disabled: always forwarded
    bus_op(0, 1, 2'd2, 8'h00);
    data_wr_chk("R5 disabled accepted", 1);

    step(); step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule